// File: doc/BRIEF.md
# Edge-Captured Fast Interrupt Pending Buffer

This block sits in a CPU control unit and buffers sixteen fast interrupt request lines. Each line is watched for a rising edge: the current input is compared against a copy registered on the previous clock. An edge on an enabled channel sets a sticky pending flag. The flag stays set after the source drops its line, and is removed only when software writes a one to the channel's bit of the pending register or disables the channel. This differs from the standard machine interrupts, which are level-sensitive and must be held by their source until software acknowledges it.

The pending flags are presented as the custom upper half of a 32-bit pending-register image, with channel n at bit 16+n. The enable word uses the same layout. A second vector holds the flags that are both pending and currently enabled, and a single flag ORs that vector for the trap controller. A downstream prioritizer would report channel n with cause code 16+n and the interrupt flag set. That prioritizer is not part of this block.

Each channel is a three-state machine. CH_OFF means the channel is disabled. CH_IDLE means it is enabled and has nothing buffered. CH_PEND means it is enabled and holds a request. The transitions are:
- T_DISABLE: any state goes to CH_OFF while the enable bit is low.
- T_ARM: CH_OFF goes to CH_IDLE when the enable bit is high and there is no edge.
- T_CAPTURE: CH_OFF or CH_IDLE goes to CH_PEND on an edge while the enable bit is high.
- T_CLEAR: CH_PEND goes to CH_IDLE on a clear without an edge.
- T_HOLD: every other case keeps the current state.

Top module: `fiq_pending_buffer`

## Requirements
- R1: Reset (rst_ni low) puts every channel in CH_OFF and zeroes the edge history. A line that is already high when reset is released therefore counts as a rising edge at the first clock.
- R2: A rising edge on line n (1 now, 0 on the previous clock) while enable bit 16+n is high sets pending bit n at that clock edge. A line held high gives no second edge.
- R3: A pending bit stays set after its line falls, as long as the channel is enabled and not cleared.
- R4: When clr_we_i is high, each bit 16+n of clr_wdata_i that is 1 clears pending bit n at the clock edge. Bits that are 0, and bits 0 to 15, have no effect.
- R5: When clr_we_i is low, clr_wdata_i changes nothing.
- R6: A rising edge in the same cycle as a clear of the same channel leaves the channel pending.
- R7: While enable bit 16+n is low, pending bit n is 0 from the next clock and edges on line n are ignored. Re-enabling while the line is still high does not capture a request. Bits 0 to 15 of the enable word are ignored.
- R8: pend_word_o bit 16+n is pending bit n, and bits 0 to 15 of pend_word_o are always 0.
- R9: pend_active_o[n] is pending bit n AND enable bit 16+n. any_active_o is the OR of pend_active_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | 16 | Raw fast interrupt request lines |
| int_enable_i | input | 32 | Enable register image; bit 16+n enables channel n |
| clr_we_i | input | 1 | Write strobe for the pending-register clear |
| clr_wdata_i | input | 32 | Clear data; a 1 at bit 16+n clears channel n |
| pend_word_o | output | 32 | Pending register image; bit 16+n is channel n |
| pend_active_o | output | 16 | Pending and enabled flags per channel |
| any_active_o | output | 1 | OR of pend_active_o |

## Verification
The assertions inside each channel check on every cycle that an enabled edge leads to pending on the next clock, and that a disabled channel is not pending one clock later. They also check that a clear without an edge drops the flag, that an untouched pending flag is held, and that a flag never rises without an enabled edge on the cycle before. Some behaviours can only be shown by the bench's scenarios: that reset history makes a held-high line count as an edge, that re-enabling under a high line captures nothing, and that a write without strobe and the low bits of the enable and clear words have no effect. The bench also shows the bit mapping across all sixteen channels.

// File: rtl/fiq_pkg.sv
package fiq_pkg;

    // Per-channel buffer state
    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,   // channel disabled, nothing buffered
        CH_IDLE = 2'd1,   // enabled, nothing buffered
        CH_PEND = 2'd2    // enabled, request buffered
    } ch_state_e;

endpackage

// File: rtl/fiq_edge_detect.sv
module fiq_edge_detect #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] lines_i,
    output logic [WIDTH-1:0] rise_o
);

    logic [WIDTH-1:0] hist_q;

    // History is kept whatever the enables say, so a disabled
    // channel still tracks its line level.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hist_q <= '0;
        end else begin
            hist_q <= lines_i;
        end
    end

    always_comb begin
        rise_o = lines_i & ~hist_q;
    end

endmodule

// File: rtl/fiq_channel.sv
module fiq_channel
    import fiq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic rise_i,
    input  logic clr_i,
    output logic pend_o
);

    ch_state_e state_q;
    ch_state_e state_d;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= CH_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (en_i) begin
                    state_d = rise_i ? CH_PEND : CH_IDLE;      // T_CAPTURE / T_ARM
                end
            end
            CH_IDLE: begin
                if (!en_i) begin
                    state_d = CH_OFF;                          // T_DISABLE
                end else if (rise_i) begin
                    state_d = CH_PEND;                         // T_CAPTURE
                end
            end
            CH_PEND: begin
                if (!en_i) begin
                    state_d = CH_OFF;                          // T_DISABLE
                end else if (clr_i && !rise_i) begin
                    state_d = CH_IDLE;                         // T_CLEAR
                end
            end
            default: begin
                state_d = CH_OFF;
            end
        endcase
    end

    // Outputs
    always_comb begin
        pend_o = (state_q == CH_PEND);
    end

    AST_EDGE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && rise_i) |=> pend_o); // R2

    AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && clr_i && !rise_i) |=> !pend_o); // R4

    AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_o && en_i && !clr_i) |=> pend_o); // R3

    AST_DISABLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !pend_o); // R7

    AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pend_o) |-> $past(en_i && rise_i)); // R2

endmodule

// File: rtl/fiq_reg_map.sv
module fiq_reg_map #(
    parameter int unsigned NUM_CH   = 16,
    parameter int unsigned REG_W    = 32,
    parameter int unsigned BASE_BIT = 16
) (
    input  logic [REG_W-1:0]  enable_word_i,
    input  logic              clr_we_i,
    input  logic [REG_W-1:0]  clr_wdata_i,
    input  logic [NUM_CH-1:0] pend_i,
    output logic [NUM_CH-1:0] en_o,
    output logic [NUM_CH-1:0] clr_o,
    output logic [REG_W-1:0]  pend_word_o,
    output logic [NUM_CH-1:0] active_o,
    output logic              any_o
);

    localparam int unsigned TOP_BIT = BASE_BIT + NUM_CH - 1;

    always_comb begin
        en_o  = enable_word_i[TOP_BIT:BASE_BIT];
        clr_o = clr_we_i ? clr_wdata_i[TOP_BIT:BASE_BIT] : '0;
    end

    always_comb begin
        pend_word_o                   = '0;
        pend_word_o[TOP_BIT:BASE_BIT] = pend_i;
        active_o                      = pend_i & en_o;
        any_o                         = |active_o;
    end

    // Standard-interrupt positions below the custom field carry nothing here
    generate
        if (BASE_BIT > 0) begin : g_low_unused
            logic unused_low;
            assign unused_low = ^{enable_word_i[BASE_BIT-1:0], clr_wdata_i[BASE_BIT-1:0]};
        end
        if (TOP_BIT < REG_W - 1) begin : g_high_unused
            logic unused_high;
            assign unused_high = ^{enable_word_i[REG_W-1:TOP_BIT+1], clr_wdata_i[REG_W-1:TOP_BIT+1]};
        end
    endgenerate

endmodule

// File: rtl/fiq_pending_buffer.sv
module fiq_pending_buffer #(
    parameter int unsigned NUM_CH   = 16,
    parameter int unsigned REG_W    = 32,
    parameter int unsigned BASE_BIT = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CH-1:0] irq_lines_i,
    input  logic [REG_W-1:0]  int_enable_i,
    input  logic              clr_we_i,
    input  logic [REG_W-1:0]  clr_wdata_i,
    output logic [REG_W-1:0]  pend_word_o,
    output logic [NUM_CH-1:0] pend_active_o,
    output logic              any_active_o
);

    logic [NUM_CH-1:0] rise;
    logic [NUM_CH-1:0] ch_en;
    logic [NUM_CH-1:0] ch_clr;
    logic [NUM_CH-1:0] ch_pend;

    fiq_edge_detect #(
        .WIDTH (NUM_CH)
    ) i_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .lines_i (irq_lines_i),
        .rise_o  (rise)
    );

    fiq_reg_map #(
        .NUM_CH   (NUM_CH),
        .REG_W    (REG_W),
        .BASE_BIT (BASE_BIT)
    ) i_map (
        .enable_word_i (int_enable_i),
        .clr_we_i      (clr_we_i),
        .clr_wdata_i   (clr_wdata_i),
        .pend_i        (ch_pend),
        .en_o          (ch_en),
        .clr_o         (ch_clr),
        .pend_word_o   (pend_word_o),
        .active_o      (pend_active_o),
        .any_o         (any_active_o)
    );

    generate
        for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
            fiq_channel i_ch (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .en_i   (ch_en[n]),
                .rise_i (rise[n]),
                .clr_i  (ch_clr[n]),
                .pend_o (ch_pend[n])
            );
        end
    endgenerate

    AST_NO_WRITE_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_we_i && ((pend_word_o[BASE_BIT+NUM_CH-1:BASE_BIT] & int_enable_i[BASE_BIT+NUM_CH-1:BASE_BIT]) != '0))
        |=> ((pend_word_o[BASE_BIT+NUM_CH-1:BASE_BIT] & $past(pend_active_o)) == $past(pend_active_o)
             || !$stable(int_enable_i))); // R5

endmodule

// File: tb/test_fiq_pending_buffer.sv
`timescale 1ns/1ps
module test_fiq_pending_buffer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq = '0;
    logic [31:0] en_w = '0;
    logic        we = 1'b0;
    logic [31:0] wd = '0;
    logic [31:0] pend_word;
    logic [15:0] pend_active;
    logic        any_active;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    logic        done     = 1'b0;

    logic [15:0] m_pend = '0;
    logic [15:0] m_prev = '0;
    logic [15:0] rs = 16'hACE1;

    always #4 clk = ~clk;

    fiq_pending_buffer i_fiq_pending_buffer (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .irq_lines_i   (irq),
        .int_enable_i  (en_w),
        .clr_we_i      (we),
        .clr_wdata_i   (wd),
        .pend_word_o   (pend_word),
        .pend_active_o (pend_active),
        .any_active_o  (any_active)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_model();
        check("R8 pend_word", pend_word, {m_pend, 16'h0000});
        check("R9 pend_active", {16'h0, pend_active}, {16'h0, m_pend & en_w[31:16]});
        check("R9 any_active", {31'h0, any_active}, {31'h0, |(m_pend & en_w[31:16])});
    endtask

    // Drive at negedge, advance one clock, compare at the next negedge
    task automatic step(input logic [15:0] l, input logic [31:0] e,
                        input logic w, input logic [31:0] d);
        logic [15:0] nxt;
        irq = l; en_w = e; we = w; wd = d;
        for (int n = 0; n < 16; n++) begin
            logic edg;
            edg = l[n] & ~m_prev[n];
            if (!e[16+n])                 nxt[n] = 1'b0;
            else if (edg)                 nxt[n] = 1'b1;
            else if (w && d[16+n])        nxt[n] = 1'b0;
            else                          nxt[n] = m_pend[n];
        end
        @(posedge clk);
        m_pend = nxt;
        m_prev = l;
        @(negedge clk);
        check_model();
    endtask

    function automatic logic [15:0] xs(input logic [15:0] v);
        logic [15:0] t;
        t = v ^ (v << 7);
        t = t ^ (t >> 9);
        t = t ^ (t << 8);
        return t;
    endfunction

    initial begin
        // R1: line 3 high across reset release counts as an edge
        irq = 16'h0008;
        repeat (3) @(negedge clk);
        check("R1 reset pend_word", pend_word, 32'h0);
        check("R1 reset any", {31'h0, any_active}, 32'h0);
        rst_n = 1'b1;
        step(16'h0008, 32'hFFFF_0000, 1'b0, 32'h0);
        check("R1 held line after reset", pend_word, 32'h0008_0000);
        step(16'h0000, 32'hFFFF_0000, 1'b1, 32'hFFFF_0000);
        check("R4 clear all", pend_word, 32'h0);

        // R2/R8: channels 0 and 15
        step(16'h8001, 32'hFFFF_0000, 1'b0, 32'h0);
        check("R2 R8 ch0 ch15", pend_word, 32'h8001_0000);
        check("R9 any", {31'h0, any_active}, 32'h1);
        // R3: lines drop, still pending
        step(16'h0000, 32'hFFFF_0000, 1'b0, 32'h0);
        check("R3 sticky", pend_word, 32'h8001_0000);
        // R5: write data without strobe
        step(16'h0000, 32'hFFFF_0000, 1'b0, 32'hFFFF_FFFF);
        check("R5 no strobe", pend_word, 32'h8001_0000);
        // R4: clear channel 0, low bits of data ignored
        step(16'h0000, 32'hFFFF_0000, 1'b1, 32'h0001_FFFF);
        check("R4 w1c ch0", pend_word, 32'h8000_0000);

        // R2: held level does not retrigger after clear
        step(16'h0020, 32'hFFFF_0000, 1'b0, 32'h0);
        step(16'h0020, 32'hFFFF_0000, 1'b1, 32'h0020_0000);
        check("R4 clear ch5", pend_word, 32'h8000_0000);
        step(16'h0020, 32'hFFFF_0000, 1'b0, 32'h0);
        check("R2 level no retrigger", pend_word, 32'h8000_0000);
        // R6: edge and clear together
        step(16'h0000, 32'hFFFF_0000, 1'b0, 32'h0);
        step(16'h0020, 32'hFFFF_0000, 1'b1, 32'h0020_0000);
        check("R6 edge beats clear", pend_word, 32'h8020_0000);

        // R7: disable ch15
        irq = 16'h0000; en_w = 32'h7FFF_0000;
        #1;
        check("R9 active drops with enable", {16'h0, pend_active}, 32'h0000_0020);
        step(16'h0000, 32'h7FFF_0000, 1'b0, 32'h0);
        check("R7 disable zeroes", pend_word, 32'h0020_0000);
        step(16'h8000, 32'h7FFF_0000, 1'b0, 32'h0);
        check("R7 edge ignored", pend_word, 32'h0020_0000);
        step(16'h8000, 32'hFFFF_0000, 1'b0, 32'h0);
        check("R7 reenable under high line", pend_word, 32'h0020_0000);
        step(16'h0000, 32'h0000_FFFF, 1'b0, 32'h0);
        check("R7 low enable bits ignored", pend_word, 32'h0);

        // Sweep every channel: capture then clear
        for (int c = 0; c < 16; c++) begin
            step(16'h0000, 32'hFFFF_0000, 1'b0, 32'h0);
            step(16'h1 << c, 32'hFFFF_0000, 1'b0, 32'h0);
            check("R8 sweep capture", pend_word, 32'h0001_0000 << c);
            step(16'h0000, 32'hFFFF_0000, 1'b1, 32'h0001_0000 << c);
            check("R4 sweep clear", pend_word, 32'h0);
        end

        // Pseudo-random run against the arithmetic model (R2..R9)
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] a, b, c2, d2;
            rs = xs(rs); a  = rs;
            rs = xs(rs); b  = rs;
            rs = xs(rs); c2 = rs;
            rs = xs(rs); d2 = rs;
            step(irq ^ (a & b), {(c2 | d2), a}, b[0] & c2[1], {(a & d2), c2});
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule